// File: doc/BRIEF.md
# Flash Command Sequencer with Status

This block is the control engine of a byte-wide NOR-style flash. It reads the stream of host byte writes, recognises unlock and command sequences, and runs timed byte-program, sector-erase and chip-erase operations on a behavioural storage array. While an operation runs, reads return a status byte: a polling bit that is the complement of the written data for a program and 0 for an erase, and a bit that toggles on every read. The host can use either bit to detect completion.

Protection works on three levels. A low write-protect pin blocks all programming and erasing. Otherwise, a low top-boot-lock pin protects the boot sector. Otherwise, a software boot lock, set by its own command sequence, does the same. A product-ID mode returns fixed identification bytes. After reset, a power-on delay must expire before any write is accepted.

All operation times are parameterised cycle counts. The behavioural array keeps `CELLS` bytes per sector. These bytes are selected by the low address bits, so every address in a sector maps onto one of those cells.

Top module: `flash_cmd_seq`

## Requirements
- R1: Reset behaviour.
  - After `rst_ni` is released, `busy_o` stays high for `POR_CYC` cycles.
  - Every array byte reads FFh.
- R2: Byte program.
  - The sequence is AAh@5555h, 55h@2AAAh, A0h@5555h, then data@address. Only address bits [14:0] are compared against the unlock addresses.
  - `busy_o` is high for exactly `PROG_CYC` cycles.
  - The cell then holds old AND new, so bits only go from 1 to 0.
  - Each sector holds `CELLS` cells, selected by `addr_i[3:0]`.
- R3: Sector erase.
  - The sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address inside the target sector.
  - After `SERASE_CYC` busy cycles, that sector reads FFh and all other sectors are unchanged.
  - Sectors by address:
    - 00000–0FFFF, 10000–1FFFF and 20000–2FFFF are main sectors.
    - 30000–37FFF is a main sector.
    - 38000–39FFF and 3A000–3BFFF are parameter sectors.
    - 3C000–3FFFF is the boot sector.
- R4: Chip erase uses the erase prefix followed by 10h@5555h. After `CHIP_CYC` busy cycles, every unprotected sector reads FFh.
- R5: Status reads.
  - While an operation is busy, a read returns {p, t, 000000b}.
  - p is NOT of data bit 7 for a program and 0 for an erase.
  - t is 0 on the first read of each operation and inverts on each following read.
- R6: Writes that arrive while `busy_o` is high, including during the power-on delay, are ignored and do not advance any sequence.
- R7: Lock priority.
  - `wp_ni` low blocks every program and erase.
  - Otherwise, `tbl_ni` low blocks programming and erasing of the boot sector.
  - Otherwise, the software lock blocks the boot sector. The software lock is set by the erase prefix followed by 40h@5555h and is cleared only by reset.
  - A blocked operation never raises `busy_o`.
- R8: Chip erase while the boot sector is locked leaves the boot sector unchanged.
- R9: Product-ID mode.
  - The entry sequence is AAh@5555h, 55h@2AAAh, 90h@5555h.
  - In ID mode, address 0 reads DAh, address 1 reads B0h and any other address reads 00h.
  - F0h written to any address, or AAh@5555h, 55h@2AAAh, F0h@5555h, returns to array reads.
- R10: A write that does not match the expected step of a sequence sends the decoder back to its idle state without starting an operation or changing the array.
- R11: `rdata_o` updates on the clock edge that samples `rd_en_i` and holds its value when `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 18 | Byte address |
| wdata_i | input | 8 | Write data |
| wp_ni | input | 1 | Active-low write protect for the whole array |
| tbl_ni | input | 1 | Active-low boot-sector lock |
| rdata_o | output | 8 | Registered read data or status byte |
| busy_o | output | 1 | High during the power-on delay or a running operation |

## Verification
A status read can fall on the same clock edge at which an operation commits to the array. Before that edge, the operation is still busy. The bench counts exactly `PROG_CYC-1` cycles after the final program write and then reads. It expects the status byte from that read, sees `busy_o` low right afterwards, and expects the programmed data from the next read. Writes during the busy window form the other overlap: a full command prefix is issued mid-operation, and the bench confirms that it had no effect once the block goes idle.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  localparam int ADDR_W   = 18;
  localparam int NSEC     = 7;
  localparam int SEC_W    = 3;
  localparam int BOOT_SEC = 6;

  localparam logic [14:0] UNL_A = 15'h5555;
  localparam logic [14:0] UNL_B = 15'h2AAA;

  localparam logic [7:0] C_KEY1  = 8'hAA;
  localparam logic [7:0] C_KEY2  = 8'h55;
  localparam logic [7:0] C_PGM   = 8'hA0;
  localparam logic [7:0] C_ERS   = 8'h80;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_EXIT  = 8'hF0;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_LOCK  = 8'h40;
  localparam logic [7:0] ID_MFR  = 8'hDA;
  localparam logic [7:0] ID_DEV  = 8'hB0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_PGM, ST_E3, ST_E4, ST_E5
  } seq_st_e;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SERASE, OP_CERASE} op_e;

  function automatic logic [SEC_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    if (a[17:16] != 2'b11)        sector_of = {1'b0, a[17:16]};
    else if (!a[15])              sector_of = 3'd3;
    else if (a[15:13] == 3'b100)  sector_of = 3'd4;
    else if (a[15:13] == 3'b101)  sector_of = 3'd5;
    else                          sector_of = 3'd6;
  endfunction
endpackage

// File: rtl/flash_op_timer.sv
`timescale 1ns/1ps
module flash_op_timer
  import flash_seq_pkg::*;
#(
  parameter int POR_CYC    = 16,
  parameter int PROG_CYC   = 10,
  parameter int SERASE_CYC = 20,
  parameter int CHIP_CYC   = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic op_busy_o,
  output logic done_o
);
  localparam int M1    = (POR_CYC > PROG_CYC) ? POR_CYC : PROG_CYC;
  localparam int M2    = (SERASE_CYC > CHIP_CYC) ? SERASE_CYC : CHIP_CYC;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             op_q;

  assign busy_o    = (cnt_q != '0);
  assign op_busy_o = op_q;
  assign done_o    = op_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(POR_CYC);
      op_q  <= 1'b0;
    end else if (start_i) begin
      op_q <= 1'b1;
      unique case (op_i)
        OP_PROG:   cnt_q <= CNT_W'(PROG_CYC);
        OP_SERASE: cnt_q <= CNT_W'(SERASE_CYC);
        default:   cnt_q <= CNT_W'(CHIP_CYC);
      endcase
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) op_q <= 1'b0;
    end
  end

  a_r6_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int CELLS  = 16,
  localparam int CELL_W = $clog2(CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  input  logic              tbl_ni,
  output logic              start_o,
  output op_e               op_o,
  output logic [SEC_W-1:0]  op_sec_o,
  output logic [CELL_W-1:0] op_cell_o,
  output logic [7:0]        op_data_o,
  output logic              boot_lock_o,
  output logic              id_mode_o
);
  seq_st_e st_q, st_d;
  logic id_q, id_d, swl_q, swl_d;
  logic acc, at_a, at_b, blocked;

  assign acc         = wr_en_i && !busy_i;
  assign at_a        = (addr_i[14:0] == UNL_A);
  assign at_b        = (addr_i[14:0] == UNL_B);
  assign op_sec_o    = sector_of(addr_i);
  assign op_cell_o   = addr_i[CELL_W-1:0];
  assign op_data_o   = wdata_i;
  assign boot_lock_o = !tbl_ni || swl_q;
  assign id_mode_o   = id_q;
  // write protect dominates; boot lock only for the boot sector
  assign blocked     = !wp_ni || ((op_sec_o == SEC_W'(BOOT_SEC)) && boot_lock_o);

  always_comb begin
    st_d    = st_q;
    id_d    = id_q;
    swl_d   = swl_q;
    start_o = 1'b0;
    op_o    = OP_NONE;
    if (acc) begin
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: begin
          if (at_a && wdata_i == C_KEY1) st_d = ST_K1;
          else if (wdata_i == C_EXIT)    id_d = 1'b0;
        end
        ST_K1: if (at_b && wdata_i == C_KEY2) st_d = ST_K2;
        ST_K2: if (at_a) begin
          if (wdata_i == C_PGM)       st_d = ST_PGM;
          else if (wdata_i == C_ERS)  st_d = ST_E3;
          else if (wdata_i == C_ID)   id_d = 1'b1;
          else if (wdata_i == C_EXIT) id_d = 1'b0;
        end
        ST_PGM: begin
          op_o    = OP_PROG;
          start_o = !blocked;
        end
        ST_E3: if (at_a && wdata_i == C_KEY1) st_d = ST_E4;
        ST_E4: if (at_b && wdata_i == C_KEY2) st_d = ST_E5;
        ST_E5: begin
          if (wdata_i == C_SECT) begin
            op_o    = OP_SERASE;
            start_o = !blocked;
          end else if (at_a && wdata_i == C_CHIP) begin
            op_o    = OP_CERASE;
            start_o = wp_ni;
          end else if (at_a && wdata_i == C_LOCK) begin
            swl_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      id_q  <= 1'b0;
      swl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      id_q  <= id_d;
      swl_q <= swl_d;
    end
  end

  a_r6_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i) |=> ($stable(st_q) && $stable(id_q) && $stable(swl_q)));
  a_r7_wp_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |-> !start_o);
endmodule

// File: rtl/flash_store.sv
`timescale 1ns/1ps
module flash_store
  import flash_seq_pkg::*;
#(
  parameter int CELLS  = 16,
  localparam int CELL_W = $clog2(CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [CELL_W-1:0] cell_i,
  input  logic [7:0]        data_i,
  input  logic              boot_lock_i,
  input  logic              done_i,
  input  logic              op_busy_i,
  input  logic              id_mode_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0]        mem [NSEC][CELLS];
  op_e               op_q;
  logic [SEC_W-1:0]  sec_q;
  logic [CELL_W-1:0] cell_q;
  logic [7:0]        data_q;
  logic              keep_boot_q, tog_q, poll_bit;
  logic [7:0]        id_byte, cur_cell, boot_cell0;

  assign poll_bit   = (op_q == OP_PROG) ? ~data_q[7] : 1'b0;
  assign cur_cell   = mem[sec_q][cell_q];
  assign boot_cell0 = mem[BOOT_SEC][0];

  always_comb begin
    if (rd_addr_i == ADDR_W'(0))      id_byte = ID_MFR;
    else if (rd_addr_i == ADDR_W'(1)) id_byte = ID_DEV;
    else                              id_byte = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSEC; s++)
        for (int c = 0; c < CELLS; c++) mem[s][c] <= 8'hFF;
      op_q        <= OP_NONE;
      sec_q       <= '0;
      cell_q      <= '0;
      data_q      <= 8'h00;
      keep_boot_q <= 1'b0;
      tog_q       <= 1'b0;
      rdata_o     <= 8'h00;
    end else begin
      if (start_i) begin
        op_q        <= op_i;
        sec_q       <= sec_i;
        cell_q      <= cell_i;
        data_q      <= data_i;
        keep_boot_q <= boot_lock_i;
        tog_q       <= 1'b0;
      end
      if (done_i) begin
        unique case (op_q)
          OP_PROG:   mem[sec_q][cell_q] <= mem[sec_q][cell_q] & data_q;
          OP_SERASE: for (int c = 0; c < CELLS; c++) mem[sec_q][c] <= 8'hFF;
          OP_CERASE:
            for (int s = 0; s < NSEC; s++)
              if (!(s == BOOT_SEC && keep_boot_q))
                for (int c = 0; c < CELLS; c++) mem[s][c] <= 8'hFF;
          default: ;
        endcase
      end
      if (rd_en_i) begin
        if (op_busy_i) begin
          rdata_o <= {poll_bit, tog_q, 6'b0};
          tog_q   <= ~tog_q;
        end else if (id_mode_i) begin
          rdata_o <= id_byte;
        end else begin
          rdata_o <= mem[sector_of(rd_addr_i)][rd_addr_i[CELL_W-1:0]];
        end
      end
    end
  end

  a_r2_prog_only_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_q == OP_PROG) |=> ((cur_cell & ~$past(cur_cell)) == 8'h00));
  a_r8_boot_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_q == OP_CERASE && keep_boot_q) |=> $stable(boot_cell0));
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int POR_CYC    = 16,
  parameter int PROG_CYC   = 10,
  parameter int SERASE_CYC = 20,
  parameter int CHIP_CYC   = 30,
  parameter int CELLS      = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [17:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wp_ni,
  input  logic        tbl_ni,
  output logic [7:0]  rdata_o,
  output logic        busy_o
);
  localparam int CELL_W = $clog2(CELLS);

  logic              start, op_busy, done, boot_lock, id_mode;
  op_e               op;
  logic [SEC_W-1:0]  op_sec;
  logic [CELL_W-1:0] op_cell;
  logic [7:0]        op_data;

  flash_cmd_fsm #(.CELLS(CELLS)) u_fsm (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .busy_i(busy_o), .wp_ni, .tbl_ni,
    .start_o(start), .op_o(op), .op_sec_o(op_sec), .op_cell_o(op_cell),
    .op_data_o(op_data), .boot_lock_o(boot_lock), .id_mode_o(id_mode)
  );

  flash_op_timer #(
    .POR_CYC(POR_CYC), .PROG_CYC(PROG_CYC),
    .SERASE_CYC(SERASE_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .op_i(op),
    .busy_o, .op_busy_o(op_busy), .done_o(done)
  );

  flash_store #(.CELLS(CELLS)) u_store (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .sec_i(op_sec),
    .cell_i(op_cell), .data_i(op_data), .boot_lock_i(boot_lock),
    .done_i(done), .op_busy_i(op_busy), .id_mode_i(id_mode),
    .rd_en_i, .rd_addr_i(addr_i), .rdata_o
  );

  a_r9_id_mfr_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && id_mode && !busy_o && addr_i == 18'h0) |=> (rdata_o == 8'hDA));
endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int POR_CYC = 16, PROG_CYC = 10, SERASE_CYC = 20, CHIP_CYC = 30;

  logic clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic wp_n = 1'b1, tbl_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        busy;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.POR_CYC(POR_CYC), .PROG_CYC(PROG_CYC),
                  .SERASE_CYC(SERASE_CYC), .CHIP_CYC(CHIP_CYC)) u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .wp_ni(wp_n), .tbl_ni(tbl_n), .rdata_o(rdata), .busy_o(busy));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [17:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [17:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic unlock(); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); endtask
  task automatic prog(logic [17:0] a, logic [7:0] d);
    unlock(); wr(18'h05555, 8'hA0); wr(a, d);
  endtask
  task automatic ers_prefix(); unlock(); wr(18'h05555, 8'h80); unlock(); endtask
  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 busy after reset", busy, 1);
    prog(18'h00100, 8'h00);  // R6: inside power-on delay
    wait_idle();
    rd(18'h00100, d); check("R1/R6 write ignored during power-on", d, 8'hFF);
    rd(18'h3C005, d); check("R1 erased array", d, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] d; int n;
    prog(18'h00100, 8'hA5);
    rd(18'h00100, d); check("R5 first status program", d, 8'h00);
    rd(18'h00100, d); check("R5 toggled status", d, 8'h40);
    rd(18'h00100, d); check("R5 toggle back", d, 8'h00);
    wait_idle();
    rd(18'h00100, d); check("R2 programmed", d, 8'hA5);
    @(negedge clk); @(negedge clk);
    check("R11 rdata holds", rdata, 8'hA5);
    prog(18'h00100, 8'h5A);
    busy_len(n); check("R2 busy length", n, PROG_CYC);
    rd(18'h00100, d); check("R2 only 1->0", d, 8'h00);
  endtask

  task automatic t_commit_edge_read();
    logic [7:0] d;
    prog(18'h10200, 8'h3C);
    repeat (PROG_CYC - 1) @(negedge clk);
    rd(18'h10200, d); check("R5 read on commit edge gives status", d, 8'h80);
    check("R2 busy drops after commit edge", busy, 0);
    rd(18'h10200, d); check("R2 data after commit", d, 8'h3C);
  endtask

  task automatic t_busy_writes();
    logic [7:0] d;
    prog(18'h20000, 8'hF0);
    unlock(); wr(18'h05555, 8'hA0);   // R6: issued while busy
    wait_idle();
    wr(18'h38000, 8'h00);
    check("R6 busy-time prefix ignored", busy, 0);
    rd(18'h38000, d); check("R6 target untouched", d, 8'hFF);
    rd(18'h20000, d); check("R2 sector2 program", d, 8'hF0);
  endtask

  task automatic t_sector_erase();
    logic [7:0] d; int n;
    ers_prefix(); wr(18'h00105, 8'h30);
    rd(18'h00105, d); check("R5 erase status", d, 8'h00);
    busy_len(n); check("R3 erase busy length", n, SERASE_CYC - 1);
    rd(18'h00100, d); check("R3 sector erased", d, 8'hFF);
    rd(18'h10200, d); check("R3 other sector kept", d, 8'h3C);
  endtask

  task automatic t_break();
    logic [7:0] d;
    unlock(); wr(18'h05555, 8'h77); wr(18'h10200, 8'h00);
    check("R10 no op after break", busy, 0);
    rd(18'h10200, d); check("R10 array unchanged", d, 8'h3C);
  endtask

  task automatic t_locks();
    logic [7:0] d;
    wp_n = 1'b0;
    prog(18'h20001, 8'h00); check("R7 wp blocks program", busy, 0);
    ers_prefix(); wr(18'h10000, 8'h30); check("R7 wp blocks sector erase", busy, 0);
    ers_prefix(); wr(18'h05555, 8'h10); check("R8 wp blocks chip erase", busy, 0);
    wp_n = 1'b1;
    rd(18'h20001, d); check("R7 wp cell kept", d, 8'hFF);
    rd(18'h10200, d); check("R8 wp array kept", d, 8'h3C);
    tbl_n = 1'b0;
    prog(18'h3C010, 8'h00); check("R7 tbl blocks boot", busy, 0);
    prog(18'h38000, 8'h11); check("R7 tbl leaves param", busy, 1);
    wait_idle(); tbl_n = 1'b1;
    rd(18'h38000, d); check("R7 param programmed", d, 8'h11);
    rd(18'h3C000, d); check("R7 boot untouched", d, 8'hFF);
    prog(18'h3C000, 8'h42); wait_idle();
    rd(18'h3C000, d); check("R7 boot open", d, 8'h42);
    ers_prefix(); wr(18'h05555, 8'h40);
    prog(18'h3C001, 8'h00); check("R7 sw lock blocks boot", busy, 0);
    ers_prefix(); wr(18'h05555, 8'h10);
    check("R4 chip erase starts", busy, 1);
    wait_idle();
    rd(18'h38000, d); check("R4 param erased", d, 8'hFF);
    rd(18'h10200, d); check("R4 main erased", d, 8'hFF);
    rd(18'h3C000, d); check("R8 boot kept", d, 8'h42);
    rd(18'h3C001, d); check("R7 sw lock cell", d, 8'hFF);
  endtask

  task automatic t_id();
    logic [7:0] d;
    prog(18'h00000, 8'h12); wait_idle();
    unlock(); wr(18'h05555, 8'h90);
    rd(18'h00000, d); check("R9 mfr code", d, 8'hDA);
    rd(18'h00001, d); check("R9 dev code", d, 8'hB0);
    rd(18'h00002, d); check("R9 other addr", d, 8'h00);
    wr(18'h01234, 8'hF0);
    rd(18'h00000, d); check("R9 one-write exit", d, 8'h12);
    unlock(); wr(18'h05555, 8'h90);
    rd(18'h00001, d); check("R9 re-entry", d, 8'hB0);
    unlock(); wr(18'h05555, 8'hF0);
    rd(18'h00000, d); check("R9 three-write exit", d, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_program();
    t_commit_edge_read();
    t_busy_writes();
    t_sector_erase();
    t_break();
    t_locks();
    t_id();
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule